// File: doc/BRIEF.md
# Register-Combining Illegal-Opcode ALU

This unit computes the result byte, status flags and stack-pointer update for the illegal 8-bit processor operations that combine registers. One of these is the rotate-after-AND operation, which has a binary form and a decimal form. The others are the AND-store and AND-with-incremented-high-byte families. The caller presents A, X, Y, an immediate byte, the high byte of the target address, the carry flag, the decimal-mode flag and a 3-bit operation code, and pulses `in_valid`.

One cycle later the registered outputs hold the result and a per-flag write mask. A stack-pointer write strobe and value are also present. The surrounding core decides how to use the result: as a memory store value, a new X, or a new accumulator. Sequencing, bus access and cycle timing stay in the core. Binary and decimal rotate-after-AND take the same single cycle here.

Top module: `undoc_combine_alu`

## Requirements
- R1: Operation codes are 0 rotate-after-AND, 1 AND-store, 2 AND-subtract-to-X, 3 X-high-store, 4 Y-high-store, 5 stack-AND-store, 6 triple-AND-store, 7 reserved. When `in_valid` is high on a rising edge, `out_valid` is high after that edge and all outputs reflect that request. When `in_valid` is low, `out_valid` drops and every other output holds. Reset clears all outputs to zero.
- R2: For the binary rotate-after-AND (code 0, `dec_mode`=0), let t1 = A & imm and t2 = {carry_in, t1[7:1]}. The result is t2, with N=t2[7], Z=(t2==0), C=t2[6] and V=t2[6]^t2[5].
- R3: In the decimal rotate-after-AND (code 0, `dec_mode`=1), the low nibble is t2[3:0]+6 modulo 16 when t1[3:0]>4, and t2[3:0] otherwise. The high nibble is t2[7:4]+6 modulo 16 with C=1 when t1[7:4]>4; otherwise it is t2[7:4] with C=0. No carry passes between nibbles.
- R4: In the decimal rotate-after-AND, N, Z and V come from the uncorrected t2, using the rules of R2.
- R5: AND-store (code 1) gives A & X and writes no flag.
- R6: AND-subtract-to-X (code 2) gives ((A & X) - imm) mod 256, with N=result[7], Z=(result==0) and C=((A & X) >= imm). V is not written.
- R7: X-high-store (code 3) gives X & (addr_hi+1), and Y-high-store (code 4) gives Y & (addr_hi+1), both modulo 256. Neither writes a flag.
- R8: Stack-AND-store (code 5) asserts `sp_we` with `sp_new` = A & X. The result is A & X & (addr_hi+1), and no flag is written.
- R9: Triple-AND-store (code 6) gives A & X & (addr_hi+1) and writes no flag.
- R10: The reserved code 7 gives result 0, no flag writes and no stack write.
- R11: `flag_we` bits are [3]=N, [2]=Z, [1]=C, [0]=V. A flag bit whose write bit is 0 reads 0. `sp_we` is 0 for every code except 5, and `sp_new` is then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code |
| a | input | 8 | Accumulator |
| x | input | 8 | X index register |
| y | input | 8 | Y index register |
| imm | input | 8 | Immediate operand |
| addr_hi | input | 8 | High byte of target address |
| carry_in | input | 1 | Current carry flag |
| dec_mode | input | 1 | Decimal-mode flag |
| out_valid | output | 1 | Result valid |
| result | output | 8 | Result byte |
| flag_n | output | 1 | New N |
| flag_z | output | 1 | New Z |
| flag_c | output | 1 | New C |
| flag_v | output | 1 | New V |
| flag_we | output | 4 | Flag write mask {N,Z,C,V} |
| sp_we | output | 1 | Stack pointer write |
| sp_new | output | 8 | New stack pointer |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing and the holding of the result while idle;
- that the rotate-after-AND's N always equals the incoming carry;
- that a stack write never comes with a flag write;
- that the stack-AND store value is a bit-subset of the new stack pointer;
- that a V write always comes with an N write.

Only the bench's scenarios show the arithmetic itself. That covers the nibble corrections at the boundary of 4 versus 5, wrap past 15 in a nibble, carry decisions in the subtract, and high-byte increment wrap at 0xFF.

// File: rtl/undoc_combine_alu.sv
module undoc_combine_alu (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [2:0] op,
  input  logic [7:0] a,
  input  logic [7:0] x,
  input  logic [7:0] y,
  input  logic [7:0] imm,
  input  logic [7:0] addr_hi,
  input  logic       carry_in,
  input  logic       dec_mode,
  output logic       out_valid,
  output logic [7:0] result,
  output logic       flag_n,
  output logic       flag_z,
  output logic       flag_c,
  output logic       flag_v,
  output logic [3:0] flag_we,
  output logic       sp_we,
  output logic [7:0] sp_new
);
  localparam logic [2:0] OP_ROR_AND = 3'd0;
  localparam logic [2:0] OP_AND_ST  = 3'd1;
  localparam logic [2:0] OP_AND_SUB = 3'd2;
  localparam logic [2:0] OP_X_HI    = 3'd3;
  localparam logic [2:0] OP_Y_HI    = 3'd4;
  localparam logic [2:0] OP_SP_AND  = 3'd5;
  localparam logic [2:0] OP_TRI_AND = 3'd6;

  logic [7:0] ax, hinc, t1, t2, fixed;
  logic [8:0] diff;
  logic       lo_fix, hi_fix;

  assign ax     = a & x;
  assign hinc   = addr_hi + 8'd1;
  assign t1     = a & imm;
  assign t2     = {carry_in, t1[7:1]};
  assign lo_fix = t1[3:0] > 4'd4;
  assign hi_fix = t1[7:4] > 4'd4;
  assign fixed  = {hi_fix ? t2[7:4] + 4'd6 : t2[7:4],
                   lo_fix ? t2[3:0] + 4'd6 : t2[3:0]};
  assign diff   = {1'b0, ax} - {1'b0, imm};

  logic [7:0] n_res, n_sp;
  logic [3:0] n_flg, n_we;
  logic       n_spwe;

  always_comb begin
    n_res  = 8'h00;
    n_flg  = 4'b0000;
    n_we   = 4'b0000;
    n_spwe = 1'b0;
    n_sp   = 8'h00;
    case (op)
      OP_ROR_AND: begin
        n_res = dec_mode ? fixed : t2;
        n_flg = {t2[7], t2 == 8'h00, dec_mode ? hi_fix : t2[6], t2[6] ^ t2[5]};
        n_we  = 4'b1111;
      end
      OP_AND_ST:  n_res = ax;
      OP_AND_SUB: begin
        n_res = diff[7:0];
        n_flg = {diff[7], diff[7:0] == 8'h00, ~diff[8], 1'b0};
        n_we  = 4'b1110;
      end
      OP_X_HI:    n_res = x & hinc;
      OP_Y_HI:    n_res = y & hinc;
      OP_SP_AND: begin
        n_res  = ax & hinc;
        n_spwe = 1'b1;
        n_sp   = ax;
      end
      OP_TRI_AND: n_res = ax & hinc;
      default:    n_res = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= 8'h00;
      {flag_n, flag_z, flag_c, flag_v} <= 4'b0000;
      flag_we   <= 4'b0000;
      sp_we     <= 1'b0;
      sp_new    <= 8'h00;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= n_res;
        {flag_n, flag_z, flag_c, flag_v} <= n_flg;
        flag_we   <= n_we;
        sp_we     <= n_spwe;
        sp_new    <= n_sp;
      end
    end
  end
endmodule

module undoc_combine_alu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [2:0] op,
  input logic       carry_in,
  input logic       out_valid,
  input logic [7:0] result,
  input logic       flag_n,
  input logic [3:0] flag_we,
  input logic       sp_we,
  input logic [7:0] sp_new
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));
  assert_ror_n_is_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd0) |=> (flag_n == $past(carry_in)));
  assert_sp_no_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> (flag_we == 4'b0000));
  assert_store_subset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> ((result & ~sp_new) == 8'h00));
  assert_v_with_n_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we[0] |-> flag_we[3]);
endmodule

bind undoc_combine_alu undoc_combine_alu_chk u_chk (.*);

// File: tb/sim_undoc_combine_alu.sv
module sim_undoc_combine_alu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] a = '0, x = '0, y = '0, imm = '0, addr_hi = '0;
  logic carry_in = 1'b0, dec_mode = 1'b0;
  logic out_valid, flag_n, flag_z, flag_c, flag_v, sp_we;
  logic [7:0] result, sp_new;
  logic [3:0] flag_we;

  always #2.5 clk = ~clk;

  undoc_combine_alu u0 (.*);

  int errors = 0, checks = 0;
  logic [24:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  last_res = 8'h00;
  bit          done = 0;

  function automatic logic [24:0] model(input int o, input int va, input int vx,
      input int vy, input int vi, input int vh, input int c, input int d);
    int ax = va & vx, h1 = (vh + 1) % 256, t1 = va & vi;
    int t2 = c * 128 + t1 / 2;
    int r = 0, n = 0, z = 0, cf = 0, v = 0, we = 0, spw = 0, sp = 0;
    case (o)
      0: begin
        r = t2; n = t2 / 128; z = (t2 == 0); cf = (t2 / 64) % 2;
        v = ((t2 / 64) % 2) ^ ((t2 / 32) % 2); we = 15;
        if (d) begin
          int lo = t2 % 16, hi = t2 / 16;
          if (t1 % 16 > 4) lo = (lo + 6) % 16;
          cf = (t1 / 16 > 4);
          if (cf) hi = (hi + 6) % 16;
          r = hi * 16 + lo;
        end
      end
      1: r = ax;
      2: begin
        r = (ax - vi + 256) % 256; n = r / 128; z = (r == 0);
        cf = (ax >= vi); we = 14;
      end
      3: r = vx & h1;
      4: r = vy & h1;
      5: begin r = ax & h1; spw = 1; sp = ax; end
      6: r = ax & h1;
      default: r = 0;
    endcase
    return {r[7:0], n[0], z[0], cf[0], v[0], we[3:0], spw[0], sp[7:0]};
  endfunction

  task automatic drive(input string tag, input int o, input int va, input int vx,
      input int vy, input int vi, input int vh, input int c, input int d);
    @(negedge clk);
    op = o[2:0]; a = va[7:0]; x = vx[7:0]; y = vy[7:0]; imm = vi[7:0];
    addr_hi = vh[7:0]; carry_in = c[0]; dec_mode = d[0]; in_valid = 1'b1;
    exp_q.push_back(model(o, va, vx, vy, vi, vh, c, d));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); in_valid = 1'b0; end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        logic [24:0] got, ex;
        string t;
        got = {result, flag_n, flag_z, flag_c, flag_v, flag_we, sp_we, sp_new};
        checks++;
        if (exp_q.size() == 0) begin
          errors++; $display("FAIL R1: unexpected out_valid got=%h expected none", got);
        end else begin
          ex = exp_q.pop_front(); t = tag_q.pop_front();
          if (got !== ex) begin
            errors++; $display("FAIL %s: got=%h expected=%h", t, got, ex);
          end
          last_res = result;
        end
      end else if (!in_valid) begin
        checks++;
        if (result !== last_res) begin
          errors++; $display("FAIL R1: idle result=%h expected=%h", result, last_res);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1: watchdog expired got=hang expected=finish");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== 8'h00 || flag_we !== 4'h0 || sp_we !== 1'b0) begin
      errors++; $display("FAIL R1: reset state out_valid=%b result=%h we=%h expected 0", out_valid, result, flag_we);
    end
    rst_n = 1'b1;
    drive("R2", 0, 'hFF, 0, 0, 'hFF, 0, 1, 0);
    drive("R2", 0, 'h01, 0, 0, 'hFF, 0, 0, 0);
    drive("R2", 0, 'hC0, 0, 0, 'hA0, 0, 0, 0);
    drive("R3", 0, 'h55, 0, 0, 'hFF, 0, 0, 1);
    drive("R3", 0, 'h44, 0, 0, 'hFF, 0, 0, 1);
    drive("R3", 0, 'hFF, 0, 0, 'hFF, 0, 1, 1);
    drive("R4", 0, 'h01, 0, 0, 'h01, 0, 0, 1);
    idle(2);
    drive("R5", 1, 'hF0, 'h3C, 0, 0, 0, 1, 0);
    drive("R6", 2, 'hFF, 'h0F, 0, 'h0F, 0, 0, 0);
    drive("R6", 2, 'hFF, 'h0F, 0, 'h10, 0, 0, 0);
    drive("R6", 2, 'h80, 'hFF, 0, 'h01, 0, 0, 0);
    drive("R7", 3, 0, 'hFF, 0, 0, 'h12, 0, 0);
    drive("R7", 4, 0, 0, 'hFF, 0, 'hFF, 0, 0);
    drive("R8", 5, 'hF7, 'h7F, 0, 0, 'h33, 0, 0);
    drive("R9", 6, 'hFF, 'hF0, 0, 0, 'h7E, 0, 0);
    drive("R10", 7, 'hFF, 'hFF, 'hFF, 'hFF, 'hFF, 1, 1);
    drive("R11", 2, 'h5A, 'hA5, 0, 0, 0, 1, 1);
    idle(3);
    for (int i = 0; i < 256; i += 7) begin
      drive("R3", 0, i, 0, 0, 'hFF - i, 0, i % 2, 1);
      drive("R2", 0, i, 0, 0, 'hFF, 0, i % 2, 0);
    end
    idle(4);
    done = 1;
    if (exp_q.size() != 0) begin
      errors++; checks++;
      $display("FAIL R1: pending=%0d expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule